// File: doc/BRIEF.md
# Signed Stack Offset Adder

This block adds a signed 8-bit displacement to a 16-bit stack pointer value and reports the result together with a fresh flag byte. The displacement is widened to 16 bits by copying its sign bit upward. The sum wraps modulo 2^16. One shared adder serves two instruction forms. In the first form the sum is written back to the stack pointer. In the second form the sum is loaded into the HL register pair and the stack pointer is left untouched.

The flags are computed from an unsigned view of the widened addition. Half-carry is the carry out of bit 11 and carry is the carry out of bit 15. Zero and subtract are always forced low. The surrounding core samples the operands with a single-cycle start strobe. One clock later it receives the registered sum, the flag byte, a done pulse and a write enable for exactly one of the two destinations. Operand fetch and the rest of the ALU belong to other blocks.

Top module: `spadd_top`

## Requirements
- R1: The cycle after `start_i` is high, `result_o` equals `sp_i + {8{disp_i[7]}, disp_i}` modulo 2^16, using the operands sampled with the start.
- R2: Flag bit 5 (half-carry) is 1 exactly when `sp_i[11:0] + sext(disp_i)[11:0]` is greater than 0xFFF.
- R3: Flag bit 4 (carry) is 1 exactly when `sp_i + sext(disp_i)`, taken as unsigned 16-bit values, is greater than 0xFFFF.
- R4: Flag bits 7 (zero) and 6 (subtract) and bits 3..0 are always 0. Every operation rebuilds the whole flag byte, so no earlier flag value carries over.
- R5: `dest_hl_i` = 0 selects the stack-pointer form, and `wr_sp_o` pulses with `done_o` while `wr_hl_o` stays 0. `dest_hl_i` = 1 selects the HL form, and `wr_hl_o` pulses while `wr_sp_o` stays 0.
- R6: `done_o` is high for exactly the one cycle after each cycle in which `start_i` is high. Back-to-back starts give back-to-back done pulses.
- R7: While no operation completes, `result_o` and `flags_o` hold their last values.
- R8: While `rst` is high (synchronous, active-high), all outputs are driven to 0 from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Sample operands and run one operation |
| dest_hl_i | input | 1 | 0: write sum to SP, 1: write sum to HL |
| sp_i | input | 16 | Current stack pointer value |
| disp_i | input | 8 | Signed displacement byte |
| result_o | output | 16 | Registered sum |
| flags_o | output | 8 | Flag byte: Z, N, H, C in bits 7..4, low nibble zero |
| wr_sp_o | output | 1 | One-cycle write enable for SP |
| wr_hl_o | output | 1 | One-cycle write enable for HL |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bound checker checks on every cycle that the registered sum, both carry flags and the constant-zero flag bits follow the operands sampled one cycle earlier. It also checks that done follows start one cycle later, that at most one write enable is high and that it agrees with the selected form, and that the outputs hold between operations. Only the bench's scenarios show that the chosen boundary operands really reach the cases of interest. These are a sum of exactly 0x10000, a carry out of bit 11 with no carry out of bit 15 and the reverse, and negative displacements that wrap below zero. The scenarios also show that a reset in the middle of the run clears the outputs, and that long runs with random gaps match a behavioural model cycle for cycle.

// File: rtl/spadd_pkg.sv
package spadd_pkg;

  typedef enum logic {
    DST_SP = 1'b0,
    DST_HL = 1'b1
  } dest_e;

  typedef struct packed {
    logic       zero;
    logic       sub;
    logic       half;
    logic       carry;
    logic [3:0] pad;
  } flag_t;

endpackage

// File: rtl/spadd_sext.sv
module spadd_sext #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] ext_o
);

  for (genvar g = 0; g < OUT_W; g++) begin : g_bit
    if (g < IN_W) begin : g_copy
      assign ext_o[g] = val_i[g];
    end else begin : g_sign
      assign ext_o[g] = val_i[IN_W-1];
    end
  end

endmodule

// File: rtl/spadd_core.sv
module spadd_core #(
  parameter int W      = 16,
  parameter int HALF_W = 12
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         half_co_o,
  output logic         full_co_o
);

  logic [HALF_W:0] low_sum;
  logic [W:0]      wide_sum;

  always_comb begin
    low_sum  = {1'b0, a_i[HALF_W-1:0]} + {1'b0, b_i[HALF_W-1:0]};
    wide_sum = {1'b0, a_i} + {1'b0, b_i};
  end

  assign sum_o     = wide_sum[W-1:0];
  assign half_co_o = low_sum[HALF_W];
  assign full_co_o = wide_sum[W];

endmodule

// File: rtl/spadd_flags.sv
module spadd_flags
  import spadd_pkg::*;
(
  input  logic  half_i,
  input  logic  carry_i,
  output flag_t flags_o
);

  always_comb begin
    flags_o       = '0;
    flags_o.zero  = 1'b0;
    flags_o.sub   = 1'b0;
    flags_o.half  = half_i;
    flags_o.carry = carry_i;
  end

endmodule

// File: rtl/spadd_top.sv
module spadd_top
  import spadd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DISP_W = 8,
  parameter int HALF_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              dest_hl_i,
  input  logic [DATA_W-1:0] sp_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [DATA_W-1:0] result_o,
  output logic [7:0]        flags_o,
  output logic              wr_sp_o,
  output logic              wr_hl_o,
  output logic              done_o
);

  localparam int FLAG_W = $bits(flag_t);

  logic [DATA_W-1:0] disp_ext;
  logic [DATA_W-1:0] sum;
  logic              half_co;
  logic              full_co;
  flag_t             flag_next;
  dest_e             dest;

  assign dest = dest_e'(dest_hl_i);

  spadd_sext #(.IN_W(DISP_W), .OUT_W(DATA_W)) u_sext (
    .val_i (disp_i),
    .ext_o (disp_ext)
  );

  spadd_core #(.W(DATA_W), .HALF_W(HALF_W)) u_core (
    .a_i       (sp_i),
    .b_i       (disp_ext),
    .sum_o     (sum),
    .half_co_o (half_co),
    .full_co_o (full_co)
  );

  spadd_flags u_flags (
    .half_i  (half_co),
    .carry_i (full_co),
    .flags_o (flag_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      flags_o  <= '0;
      wr_sp_o  <= 1'b0;
      wr_hl_o  <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o  <= start_i;
      wr_sp_o <= start_i && (dest == DST_SP);
      wr_hl_o <= start_i && (dest == DST_HL);
      if (start_i) begin
        result_o <= sum;
        flags_o  <= FLAG_W'(flag_next);
      end
    end
  end

endmodule

// File: rtl/spadd_chk.sv
module spadd_chk #(
  parameter int DATA_W = 16,
  parameter int DISP_W = 8,
  parameter int HALF_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              dest_hl_i,
  input logic [DATA_W-1:0] sp_i,
  input logic [DISP_W-1:0] disp_i,
  input logic [DATA_W-1:0] result_o,
  input logic [7:0]        flags_o,
  input logic              wr_sp_o,
  input logic              wr_hl_o,
  input logic              done_o
);

  logic [DATA_W-1:0] m_ext;
  logic [DATA_W:0]   m_wide;
  logic [HALF_W:0]   m_low;

  always_comb begin
    m_ext  = {{(DATA_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
    m_wide = {1'b0, sp_i} + {1'b0, m_ext};
    m_low  = {1'b0, sp_i[HALF_W-1:0]} + {1'b0, m_ext[HALF_W-1:0]};
  end

  // R1
  assert_sum_R1: assert property (@(posedge clk) disable iff (rst)
    start_i |=> result_o == $past(m_wide[DATA_W-1:0]));

  // R2
  assert_half_R2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> flags_o[5] == $past(m_low[HALF_W]));

  // R3
  assert_carry_R3: assert property (@(posedge clk) disable iff (rst)
    start_i |=> flags_o[4] == $past(m_wide[DATA_W]));

  // R4
  assert_zero_bits_R4: assert property (@(posedge clk) disable iff (rst)
    flags_o[7:6] == 2'b00 && flags_o[3:0] == 4'h0);

  // R5
  assert_one_dest_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_sp_o, wr_hl_o}) && (done_o == (wr_sp_o | wr_hl_o)));

  assert_dest_sel_R5: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (wr_hl_o == $past(dest_hl_i)));

  // R6
  assert_done_R6: assert property (@(posedge clk) disable iff (rst)
    start_i |=> done_o);

  assert_no_done_R6: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> !done_o);

  // R7
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> $stable(result_o) && $stable(flags_o));

  // R8
  assert_reset_R8: assert property (@(posedge clk)
    rst |=> result_o == '0 && flags_o == 8'h00 && !done_o && !wr_sp_o && !wr_hl_o);

endmodule

bind spadd_top spadd_chk #(
  .DATA_W (DATA_W),
  .DISP_W (DISP_W),
  .HALF_W (HALF_W)
) u_spadd_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .dest_hl_i (dest_hl_i),
  .sp_i      (sp_i),
  .disp_i    (disp_i),
  .result_o  (result_o),
  .flags_o   (flags_o),
  .wr_sp_o   (wr_sp_o),
  .wr_hl_o   (wr_hl_o),
  .done_o    (done_o)
);

// File: tb/test_spadd_top.sv
module test_spadd_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        dest_hl_i = 1'b0;
  logic [15:0] sp_i = '0;
  logic [7:0]  disp_i = '0;
  logic [15:0] result_o;
  logic [7:0]  flags_o;
  logic        wr_sp_o;
  logic        wr_hl_o;
  logic        done_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // model state: what outputs should show after the next edge
  int exp_res = 0;
  int exp_flags = 0;
  bit exp_done = 0;
  bit exp_wsp = 0;
  bit exp_whl = 0;
  bit prev_start = 0;
  bit prev_rst = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  spadd_top i_spadd_top (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .dest_hl_i (dest_hl_i),
    .sp_i      (sp_i),
    .disp_i    (disp_i),
    .result_o  (result_o),
    .flags_o   (flags_o),
    .wr_sp_o   (wr_sp_o),
    .wr_hl_o   (wr_hl_o),
    .done_o    (done_o)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // compare current outputs with model, then advance model by the inputs
  // that the next rising edge will capture
  task automatic step(bit r, bit s, bit hl, int sp, int d);
    int dx;
    int sum;
    int low;
    @(negedge clk);
    if (prev_rst) begin
      check("R8 result", int'(result_o), 0);
      check("R8 flags", int'(flags_o), 0);
      check("R8 strobes", int'({done_o, wr_sp_o, wr_hl_o}), 0);
    end else begin
      check(prev_start ? "R1 result" : "R7 result hold", int'(result_o), exp_res);
      check("R2 half-carry", int'(flags_o[5]), (exp_flags >> 5) & 1);
      check("R3 carry", int'(flags_o[4]), (exp_flags >> 4) & 1);
      check(prev_start ? "R4 zero bits" : "R7 flags hold",
            int'({flags_o[7:6], flags_o[3:0]}), 0);
      check("R5 write enables", int'({wr_sp_o, wr_hl_o}), int'({exp_wsp, exp_whl}));
      check("R6 done", int'(done_o), int'(exp_done));
    end
    rst = r; start_i = s; dest_hl_i = hl; sp_i = sp[15:0]; disp_i = d[7:0];
    if (r) begin
      exp_res = 0; exp_flags = 0; exp_done = 0; exp_wsp = 0; exp_whl = 0;
    end else begin
      exp_done = s;
      exp_wsp = s && !hl;
      exp_whl = s && hl;
      if (s) begin
        dx = (d & 8'h80) != 0 ? (d & 8'hFF) + 16'hFF00 : (d & 8'hFF);
        sum = (sp & 16'hFFFF) + dx;
        low = (sp & 12'hFFF) + (dx & 12'hFFF);
        exp_res = sum % 65536;
        exp_flags = ((low > 12'hFFF) ? 8'h20 : 0) | ((sum > 16'hFFFF) ? 8'h10 : 0);
      end
    end
    prev_start = s && !r;
    prev_rst = r;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);                    // R8 reset state observed
    // boundary cases
    step(0, 1, 0, 16'hFFFF, 8'h01);         // R2 R3: both carries, wraps to 0
    step(0, 1, 1, 16'h0FFF, 8'h01);         // R2 only, HL form (R5)
    step(0, 1, 0, 16'h0001, 8'hFF);         // R1 negative displacement, both carries
    step(0, 1, 1, 16'h8000, 8'h80);         // R3 only, negative wrap
    step(0, 1, 0, 16'h0000, 8'h80);         // no carry, wraps below zero
    step(0, 1, 0, 16'h1234, 8'h7F);         // largest positive displacement
    step(0, 0, 1, 16'hAAAA, 8'h55);         // R7 ignored operands while idle
    step(0, 0, 0, 16'h5555, 8'hAA);
    step(0, 1, 1, 16'h00F0, 8'h10);         // R4 flags rebuilt after carries
    step(0, 1, 0, 16'hFFFF, 8'h00);         // zero displacement
    step(0, 0, 0, 0, 0);
    // random traffic with gaps, back-to-back starts (R6)
    for (int i = 0; i < 3000; i++) begin
      step(0, ($urandom % 3) != 0, $urandom % 2, $urandom % 65536, $urandom % 256);
    end
    step(1, 1, 0, 16'hFFFF, 8'hFF);         // R8 reset wins over start
    step(0, 0, 0, 0, 0);
    for (int i = 0; i < 500; i++) begin
      step(0, $urandom % 2, $urandom % 2, $urandom % 65536, $urandom % 256);
    end
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule